// File: doc/BRIEF.md
# Byte-Lane Write Strobe and Output Drive Control

This block sits at the control side of a synchronous memory port. On every rising clock edge it samples the write-control inputs and turns them into one active-high write strobe per 9-bit byte lane. These strobes go to the storage array on the following cycle. A full-word write request overrides the per-lane requests. Per-lane requests count only while the lane-write qualifier is asserted, and nothing is written unless the port's registered chip-selected flag is true.

The block also registers the incoming write data, so the data arrives at the array in step with the strobes. It expands the strobes into a per-bit write mask. Each lane holds eight data bits plus one parity bit. The block also produces the enable for the port's data output drivers. Drivers are on only when the asynchronous output-enable input is low, the port was selected at the last edge, and no lane is being written in the current cycle. A sleep input freezes every register while it is high.

Top module: `bwo_port_ctl`

## Requirements
- R1: While the synchronous active-high reset is high at a clock edge, all strobes, the registered data and the selected flag are cleared after that edge. Reset overrides sleep. With the selected flag cleared, `drive_en_o` is 0.
- R2: The sampled inputs at an edge are `sleep_i` low, `sel_i` high and `gwr_n_i` low. After that edge all four strobes are 1, regardless of `bwen_n_i` and `lane_we_n_i`.
- R3: The sampled inputs at an edge are `sleep_i` low, `sel_i` high, `gwr_n_i` high and `bwen_n_i` low. After that edge, strobe k equals the inverse of `lane_we_n_i[k]`.
- R4: The sampled inputs at an edge are `gwr_n_i` high and `bwen_n_i` high, with `sleep_i` low. After that edge all strobes are 0, whatever `lane_we_n_i` holds.
- R5: The sampled inputs at an edge are `sel_i` low and `sleep_i` low. After that edge all strobes are 0, whatever the write inputs hold.
- R6: When `sleep_i` is low at an edge, `wdata_q_o` equals the `wdata_i` sampled at that edge until the next edge.
- R7: Lane k covers data bits [8k+7:8k] and parity bit 32+k of the 36-bit word. Every bit of `wmask_o` equals the strobe of its lane.
- R8: `drive_en_o` is 1 exactly when `oe_n_i` is low, the selected flag registered at the last edge is 1, and no strobe is active. It follows `oe_n_i` with no clock edge in between.
- R9: When `sleep_i` is high at an edge and reset is low, the strobes, the registered data and the selected flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | High freezes all registers |
| sel_i | input | 1 | Registered chip-selected flag from the port |
| gwr_n_i | input | 1 | Active-low write of all lanes |
| bwen_n_i | input | 1 | Active-low qualifier for the per-lane requests |
| lane_we_n_i | input | 4 | Active-low per-lane write requests |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| wdata_i | input | 36 | Write data: 32 data bits, parity in [35:32] |
| lane_strb_o | output | 4 | Registered active-high lane write strobes |
| wmask_o | output | 36 | Per-bit write mask from the strobes |
| wdata_q_o | output | 36 | Registered write data |
| drive_en_o | output | 1 | Data output driver enable |

## Verification
The strobes, the mask and the registered data are due one edge after the inputs that cause them. The bench drives inputs on the falling edge and updates its reference model at the next rising edge. It compares shortly after the following falling edge, so each result is checked in the one cycle it belongs to. The drive enable has no register on its output-enable path. The bench therefore checks it 1 ns after `oe_n_i` changes, with no edge in between, against the model's registered selected flag and strobes.

// File: rtl/bwo_pkg.sv
package bwo_pkg;
  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_GLOBAL = 2'd1,
    WK_LANES  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/bwo_wr_decode.sv
module bwo_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             sel,
  input  logic             gwr_n,
  input  logic             bwen_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] strb_q
);
  import bwo_pkg::*;

  wr_kind_e         kind;
  logic [LANES-1:0] strb_d;

  always_comb begin
    if (!sel)           kind = WK_NONE;
    else if (!gwr_n)    kind = WK_GLOBAL;
    else if (!bwen_n)   kind = WK_LANES;
    else                kind = WK_NONE;
  end

  always_comb begin
    case (kind)
      WK_GLOBAL: strb_d = '1;
      WK_LANES:  strb_d = ~lane_n;
      default:   strb_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        strb_q <= '0;
    else if (!hold) strb_q <= strb_d;
  end
endmodule

// File: rtl/bwo_data_reg.sv
module bwo_data_reg #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/bwo_lane_map.sv
module bwo_lane_map #(
  parameter int LANES   = 4,
  parameter int LANE_DW = 8
) (
  input  logic [LANES-1:0]             strb,
  output logic [LANES*(LANE_DW+1)-1:0] mask
);
  localparam int PAR_BASE = LANES * LANE_DW;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar j = 0; j < LANE_DW; j++) begin : g_bit
      assign mask[k*LANE_DW + j] = strb[k];
    end
    assign mask[PAR_BASE + k] = strb[k];
  end
endmodule

// File: rtl/bwo_out_ctl.sv
module bwo_out_ctl #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             sel,
  input  logic             oe_n,
  input  logic [LANES-1:0] strb,
  output logic             drive_en
);
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst)        sel_q <= 1'b0;
    else if (!hold) sel_q <= sel;
  end

  // asynchronous path from oe_n; write activity forces drivers off
  assign drive_en = !oe_n && sel_q && !(|strb);
endmodule

// File: rtl/bwo_port_ctl.sv
module bwo_port_ctl #(
  parameter int LANES   = 4,
  parameter int LANE_DW = 8,
  localparam int LANE_W = LANE_DW + 1,
  localparam int DW     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             sel_i,
  input  logic             gwr_n_i,
  input  logic             bwen_n_i,
  input  logic [LANES-1:0] lane_we_n_i,
  input  logic             oe_n_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [LANES-1:0] lane_strb_o,
  output logic [DW-1:0]    wmask_o,
  output logic [DW-1:0]    wdata_q_o,
  output logic             drive_en_o
);
  bwo_wr_decode #(.LANES(LANES)) u_dec (
    .clk(clk), .rst(rst), .hold(sleep_i), .sel(sel_i),
    .gwr_n(gwr_n_i), .bwen_n(bwen_n_i), .lane_n(lane_we_n_i),
    .strb_q(lane_strb_o)
  );

  bwo_data_reg #(.DW(DW)) u_dreg (
    .clk(clk), .rst(rst), .hold(sleep_i), .d(wdata_i), .q(wdata_q_o)
  );

  bwo_lane_map #(.LANES(LANES), .LANE_DW(LANE_DW)) u_map (
    .strb(lane_strb_o), .mask(wmask_o)
  );

  bwo_out_ctl #(.LANES(LANES)) u_oct (
    .clk(clk), .rst(rst), .hold(sleep_i), .sel(sel_i),
    .oe_n(oe_n_i), .strb(lane_strb_o), .drive_en(drive_en_o)
  );
endmodule

// File: rtl/bwo_port_ctl_chk.sv
module bwo_port_ctl_chk #(
  parameter int LANES   = 4,
  parameter int LANE_DW = 8,
  localparam int DW     = LANES * (LANE_DW + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_i,
  input logic             sel_i,
  input logic             gwr_n_i,
  input logic             bwen_n_i,
  input logic [LANES-1:0] lane_we_n_i,
  input logic             oe_n_i,
  input logic [DW-1:0]    wdata_i,
  input logic [LANES-1:0] lane_strb_o,
  input logic [DW-1:0]    wmask_o,
  input logic [DW-1:0]    wdata_q_o,
  input logic             drive_en_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (lane_strb_o == '0 && wdata_q_o == '0 && !drive_en_o));
  // R2
  global_all_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && sel_i && !gwr_n_i) |=> (&lane_strb_o));
  // R3
  lane_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !sleep_i && sel_i && gwr_n_i && !bwen_n_i) |=> (lane_strb_o == ~$past(lane_we_n_i)));
  // R4
  qual_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && gwr_n_i && bwen_n_i) |=> (lane_strb_o == '0));
  // R5
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && !sel_i) |=> (lane_strb_o == '0));
  // R6
  data_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !sleep_i) |=> (wdata_q_o == $past(wdata_i)));
  // R7
  mask_count_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(wmask_o) == $countones(lane_strb_o) * (LANE_DW + 1)));
  // R8
  drive_off_chk: assert property (@(posedge clk) disable iff (rst)
    drive_en_o |-> (!oe_n_i && lane_strb_o == '0));
  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && sleep_i) |=> ($stable(lane_strb_o) && $stable(wdata_q_o)));
endmodule

bind bwo_port_ctl bwo_port_ctl_chk #(.LANES(LANES), .LANE_DW(LANE_DW)) u_chk (
  .clk(clk), .rst(rst), .sleep_i(sleep_i), .sel_i(sel_i), .gwr_n_i(gwr_n_i),
  .bwen_n_i(bwen_n_i), .lane_we_n_i(lane_we_n_i), .oe_n_i(oe_n_i),
  .wdata_i(wdata_i), .lane_strb_o(lane_strb_o), .wmask_o(wmask_o),
  .wdata_q_o(wdata_q_o), .drive_en_o(drive_en_o)
);

// File: tb/bwo_port_ctl_tb.sv
module bwo_port_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep_i = 1'b0, sel_i = 1'b0, gwr_n_i = 1'b1, bwen_n_i = 1'b1, oe_n_i = 1'b1;
  logic [3:0]  lane_we_n_i = 4'hF;
  logic [35:0] wdata_i = '0;
  logic [3:0]  lane_strb_o;
  logic [35:0] wmask_o, wdata_q_o;
  logic        drive_en_o;

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // reference model state
  logic [3:0]  m_strb = '0;
  logic [35:0] m_data = '0;
  logic        m_sel  = 1'b0;

  always #5 clk = ~clk;

  bwo_port_ctl u_dut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .sel_i(sel_i), .gwr_n_i(gwr_n_i),
    .bwen_n_i(bwen_n_i), .lane_we_n_i(lane_we_n_i), .oe_n_i(oe_n_i),
    .wdata_i(wdata_i), .lane_strb_o(lane_strb_o), .wmask_o(wmask_o),
    .wdata_q_o(wdata_q_o), .drive_en_o(drive_en_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_strb <= '0; m_data <= '0; m_sel <= 1'b0;
    end else if (!sleep_i) begin
      m_data <= wdata_i;
      m_sel  <= sel_i;
      if (!sel_i)         m_strb <= 4'h0;
      else if (!gwr_n_i)  m_strb <= 4'hF;
      else if (!bwen_n_i) m_strb <= ~lane_we_n_i;
      else                m_strb <= 4'h0;
    end
  end

  function automatic logic [35:0] exp_mask(input logic [3:0] s);
    logic [35:0] m;
    for (int b = 0; b < 36; b++) m[b] = (b < 32) ? s[b / 8] : s[b - 32];
    return m;
  endfunction

  task automatic cmp(input string what, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("strobes", {32'h0, lane_strb_o}, {32'h0, m_strb});
    cmp("data", wdata_q_o, m_data);
    cmp("mask R7", wmask_o, exp_mask(m_strb));
    cmp("drive R8", {35'h0, drive_en_o}, {35'h0, (!oe_n_i && m_sel && m_strb == 4'h0)});
  endtask

  task automatic step(input logic sel, input logic gw, input logic bw, input logic [3:0] ln,
                      input logic oe, input logic slp, input logic [35:0] d);
    @(negedge clk);
    sel_i = sel; gwr_n_i = gw; bwen_n_i = bw; lane_we_n_i = ln;
    oe_n_i = oe; sleep_i = slp; wdata_i = d;
    #1 check_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    tag = "R1";
    step(1, 0, 0, 4'h0, 0, 0, 36'h123456789);
    @(negedge clk); rst = 1'b0;
    #1 check_all();

    tag = "R2";
    step(1, 0, 1, 4'hF, 1, 0, 36'hA_0000_0001);
    step(1, 0, 0, 4'hA, 1, 0, 36'h5_FFFF_FFFF);
    step(1, 1, 1, 4'hF, 0, 0, 36'h0_1234_5678);
    step(1, 1, 1, 4'hF, 0, 0, 36'h0_1234_5678);

    tag = "R3";
    for (int p = 0; p < 16; p++) step(1, 1, 0, p[3:0], 1, 0, {p[3:0], 32'hDEAD_0000 + p});

    tag = "R4";
    step(1, 1, 1, 4'h0, 1, 0, 36'h1);
    step(1, 1, 1, 4'h5, 1, 0, 36'h2);
    step(1, 1, 1, 4'h5, 1, 0, 36'h2);

    tag = "R5";
    step(0, 0, 0, 4'h0, 0, 0, 36'h3);
    step(0, 1, 0, 4'h0, 0, 0, 36'h4);
    step(0, 1, 1, 4'hF, 0, 0, 36'h4);

    tag = "R6";
    step(1, 1, 1, 4'hF, 1, 0, 36'hF_FFFF_FFFF);
    step(1, 1, 1, 4'hF, 1, 0, 36'h0_0000_0000);
    step(1, 1, 1, 4'hF, 1, 0, 36'h9_A5A5_5A5A);
    step(1, 1, 1, 4'hF, 1, 0, 36'h6_5A5A_A5A5);

    tag = "R7";
    step(1, 1, 0, 4'hE, 1, 0, 36'h0);
    step(1, 1, 0, 4'h7, 1, 0, 36'h0);
    step(1, 1, 0, 4'hB, 1, 0, 36'h0);

    tag = "R8";
    step(1, 1, 1, 4'hF, 0, 0, 36'h7);
    step(1, 1, 1, 4'hF, 0, 0, 36'h7);
    #2 oe_n_i = 1'b1; #1 check_all();
    #1 oe_n_i = 1'b0; #1 check_all();
    step(1, 0, 1, 4'hF, 0, 0, 36'h8);
    step(1, 1, 1, 4'hF, 0, 0, 36'h8);
    step(0, 1, 1, 4'hF, 0, 0, 36'h8);
    step(0, 1, 1, 4'hF, 0, 0, 36'h8);

    tag = "R9";
    step(1, 1, 0, 4'h6, 0, 0, 36'hC_CAFE_F00D);
    step(0, 1, 1, 4'hF, 0, 1, 36'h1_1111_1111);
    step(1, 0, 0, 4'h0, 0, 1, 36'h2_2222_2222);
    step(1, 0, 0, 4'h0, 0, 1, 36'h3_3333_3333);
    step(1, 1, 1, 4'hF, 0, 0, 36'h4);
    step(1, 1, 1, 4'hF, 0, 0, 36'h4);

    tag = "R1";
    step(1, 0, 0, 4'h0, 0, 0, 36'h5_5555_5555);
    step(1, 0, 0, 4'h0, 0, 1, 36'h5_5555_5555);
    @(negedge clk); rst = 1'b1;
    #1 check_all();
    @(negedge clk); #1 check_all();
    @(negedge clk); rst = 1'b0; sleep_i = 1'b0;
    #1 check_all();

    tag = "R3";
    for (int i = 0; i < 200; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1),
           4'($urandom), $urandom_range(0, 1), $urandom_range(0, 5) == 0,
           {4'($urandom), 32'($urandom)});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule